// File: doc/BRIEF.md
# Memory Request Timing Monitor

This block is a passive observer placed beside a memory controller's command path. Each cycle it is shown at most one decoded request, which is an activate, read, write or precharge together with its bank number. It is also shown one bit that says whether a data packet is on the data bus. It keeps a row-open flag and elapsed-cycle counters for each bank. With these it judges every request against the minimum spacing rules. It also judges every data packet against the fixed latency that its column command sets. Reads and writes have their own activate-to-column minimum, their own column-to-precharge minimum and their own data latency.

A violation never stops or alters traffic. Each kind of violation sets its own sticky flag. The code and bank of the first violation seen since the last clear are held for readout. A pulse on the clear input empties the log. Requests that break a rule still update the bank state, just as a legal request would.

Top module: `rtm_monitor`

## Requirements
- R1: Request opcodes are 0 = activate, 1 = read, 2 = write, 3 = precharge. An activate to a bank whose row is open logs code 1. A read or write to a bank with no open row logs code 2.
- R2: A read fewer than 5 cycles after the activate of its bank logs code 3. A write fewer than 1 cycle after that activate logs code 4. A read exactly 5 cycles and a write exactly 1 cycle after the activate log nothing.
- R3: Two column commands (read or write, any banks) fewer than 2 cycles apart log code 5 against the later command's bank.
- R4: A precharge fewer than 3 cycles after the last read to its bank logs code 6. Exactly 3 cycles logs nothing.
- R5: A precharge fewer than 10 cycles after the last write to its bank logs code 7. Exactly 10 cycles logs nothing.
- R6: Data must be valid exactly 6 cycles after each read and exactly 3 cycles after each write. If it is absent then, code 8 is logged with that command's bank. When two commands expect data in the same cycle, the later-issued command's bank is used.
- R7: Data valid in a cycle where no command expects data logs code 9 with bank 0.
- R8: Output `err_flags` bit i is the sticky flag of code i+1. A flag is set one cycle after its violation and holds until `err_clear` is high. A violation in the same cycle as `err_clear` is still recorded.
- R9: `err_code` and `err_bank` hold the first violation since reset or the last clear. When several codes arise in one cycle, the lowest code wins.
- R10: Banks are tracked independently. A precharge to a closed bank with no recent column commands logs nothing. Timing on one bank is not affected by requests to another bank.
- R11: After reset, all flags, the code and the bank are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A request is present this cycle |
| cmd_op | input | 2 | Request opcode (see R1) |
| cmd_bank | input | 3 | Bank of the request |
| data_valid | input | 1 | A data packet is on the bus this cycle |
| err_clear | input | 1 | Empties the error log |
| err_flags | output | 9 | Sticky flag per violation code |
| err_code | output | 4 | Code of the first logged violation, 0 if none |
| err_bank | output | 3 | Bank of the first logged violation |

## Verification
The data-window check and the request-spacing checks can fire in the same cycle. For example, a read that comes too soon after another read can share its cycle with an unexpected data packet. The bench forces this case directly by driving a read one cycle after another read while holding data valid. It expects both flags to be set and code 5 to beat code 9 for the first-error readout. Random traffic with occasional wrong data-valid values hits further such overlaps. Each one is judged against a reference model that uses absolute cycle stamps.

// File: rtl/rtm_pkg.sv
package rtm_pkg;

  typedef enum logic [1:0] {
    OP_ACT = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2,
    OP_PRE = 2'd3
  } op_e;

  localparam int NCODE = 9;
  localparam int CODEW = 4;

  // violation codes; flag bit index is code-1
  localparam logic [CODEW-1:0] C_ACT_OPEN   = 4'd1;
  localparam logic [CODEW-1:0] C_COL_CLOSED = 4'd2;
  localparam logic [CODEW-1:0] C_RD_EARLY   = 4'd3;
  localparam logic [CODEW-1:0] C_WR_EARLY   = 4'd4;
  localparam logic [CODEW-1:0] C_COL_GAP    = 4'd5;
  localparam logic [CODEW-1:0] C_PRE_RD     = 4'd6;
  localparam logic [CODEW-1:0] C_PRE_WR     = 4'd7;
  localparam logic [CODEW-1:0] C_DATA_MISS  = 4'd8;
  localparam logic [CODEW-1:0] C_DATA_EXTRA = 4'd9;

  // elapsed cycles shorter than the required minimum
  function automatic logic gap_short(input logic [15:0] elapsed,
                                     input logic [15:0] min_gap);
    return elapsed < min_gap;
  endfunction

  // lowest code among the raised violations, 0 if none
  function automatic logic [CODEW-1:0] first_code(input logic [NCODE-1:0] hits);
    logic [CODEW-1:0] r;
    r = '0;
    for (int i = NCODE - 1; i >= 0; i--) begin
      if (hits[i]) r = CODEW'(i + 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/rtm_bank_tracker.sv
module rtm_bank_tracker
  import rtm_pkg::*;
#(
  parameter int CNTW       = 5,
  parameter int RD_ACT_MIN = 5,
  parameter int WR_ACT_MIN = 1,
  parameter int RD_PRE_MIN = 3,
  parameter int WR_PRE_MIN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  op_e  op,
  output logic row_open,
  output logic e_act_open,
  output logic e_col_closed,
  output logic e_rd_early,
  output logic e_wr_early,
  output logic e_pre_rd,
  output logic e_pre_wr
);

  localparam int AGE_ACT = 0;
  localparam int AGE_RD  = 1;
  localparam int AGE_WR  = 2;
  localparam int NAGE    = 3;

  logic is_act, is_rd, is_wr, is_pre;
  assign is_act = hit && (op == OP_ACT);
  assign is_rd  = hit && (op == OP_RD);
  assign is_wr  = hit && (op == OP_WR);
  assign is_pre = hit && (op == OP_PRE);

  logic [NAGE-1:0] age_evt;
  assign age_evt = {is_wr, is_rd, is_act};

  // cycles elapsed since each event kind, saturating at all ones
  logic [CNTW-1:0] age [NAGE];

  for (genvar g = 0; g < NAGE; g++) begin : g_age
    always_ff @(posedge clk) begin
      if (!rst_n)                age[g] <= '1;
      else if (age_evt[g])       age[g] <= CNTW'(1);
      else if (age[g] != '1)     age[g] <= age[g] + CNTW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      row_open <= 1'b0;
    else if (is_act) row_open <= 1'b1;
    else if (is_pre) row_open <= 1'b0;
  end

  assign e_act_open   = is_act && row_open;
  assign e_col_closed = (is_rd || is_wr) && !row_open;
  assign e_rd_early   = is_rd  && gap_short(16'(age[AGE_ACT]), 16'(RD_ACT_MIN));
  assign e_wr_early   = is_wr  && gap_short(16'(age[AGE_ACT]), 16'(WR_ACT_MIN));
  assign e_pre_rd     = is_pre && gap_short(16'(age[AGE_RD]),  16'(RD_PRE_MIN));
  assign e_pre_wr     = is_pre && gap_short(16'(age[AGE_WR]),  16'(WR_PRE_MIN));

endmodule

// File: rtl/rtm_data_window.sv
module rtm_data_window #(
  parameter int RD_LAT = 6,
  parameter int WR_LAT = 3,
  parameter int BW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_issue,
  input  logic          wr_issue,
  input  logic [BW-1:0] bank,
  input  logic          data_valid,
  output logic          exp_now,
  output logic [BW-1:0] exp_bank,
  output logic          e_miss,
  output logic          e_extra
);

  localparam int DEPTH = (RD_LAT > WR_LAT) ? RD_LAT : WR_LAT;

  // slot k: data expected k cycles after the current one
  logic [DEPTH-1:0] slot;
  logic [BW-1:0]    sbank [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot <= '0;
      for (int k = 0; k < DEPTH; k++) sbank[k] <= '0;
    end else begin
      for (int k = 0; k < DEPTH - 1; k++) begin
        slot[k]  <= slot[k+1];
        sbank[k] <= sbank[k+1];
      end
      slot[DEPTH-1] <= 1'b0;
      if (rd_issue) begin
        slot[RD_LAT-1]  <= 1'b1;
        sbank[RD_LAT-1] <= bank;
      end
      if (wr_issue) begin
        slot[WR_LAT-1]  <= 1'b1;
        sbank[WR_LAT-1] <= bank;
      end
    end
  end

  assign exp_now  = slot[0];
  assign exp_bank = sbank[0];
  assign e_miss   = exp_now && !data_valid;
  assign e_extra  = data_valid && !exp_now;

endmodule

// File: rtl/rtm_err_log.sv
module rtm_err_log
  import rtm_pkg::*;
#(
  parameter int BW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_clear,
  input  logic [NCODE-1:0] hits,
  input  logic [CODEW-1:0] new_code,
  input  logic [BW-1:0]    new_bank,
  output logic [NCODE-1:0] flags,
  output logic [CODEW-1:0] code,
  output logic [BW-1:0]    bank
);

  logic log_empty;
  assign log_empty = (flags == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      code  <= '0;
      bank  <= '0;
    end else begin
      flags <= err_clear ? hits : (flags | hits);
      if ((|hits) && (err_clear || log_empty)) begin
        code <= new_code;
        bank <= new_bank;
      end else if (err_clear) begin
        code <= '0;
        bank <= '0;
      end
    end
  end

endmodule

// File: rtl/rtm_monitor.sv
module rtm_monitor
  import rtm_pkg::*;
#(
  parameter int NBANK       = 8,
  parameter int RD_ACT_MIN  = 5,
  parameter int WR_ACT_MIN  = 1,
  parameter int COL_GAP_MIN = 2,
  parameter int RD_PRE_MIN  = 3,
  parameter int WR_PRE_MIN  = 10,
  parameter int RD_LAT      = 6,
  parameter int WR_LAT      = 3,
  localparam int BW         = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [BW-1:0]    cmd_bank,
  input  logic             data_valid,
  input  logic             err_clear,
  output logic [NCODE-1:0] err_flags,
  output logic [CODEW-1:0] err_code,
  output logic [BW-1:0]    err_bank
);

  localparam int MAX_A   = (RD_ACT_MIN > WR_ACT_MIN) ? RD_ACT_MIN : WR_ACT_MIN;
  localparam int MAX_P   = (RD_PRE_MIN > WR_PRE_MIN) ? RD_PRE_MIN : WR_PRE_MIN;
  localparam int MAX_AP  = (MAX_A > MAX_P) ? MAX_A : MAX_P;
  localparam int MAX_MIN = (MAX_AP > COL_GAP_MIN) ? MAX_AP : COL_GAP_MIN;
  localparam int CNTW    = $clog2(MAX_MIN + 1) + 1;

  op_e op;
  assign op = op_e'(cmd_op);

  logic rd_issue, wr_issue, col_issue;
  assign rd_issue  = cmd_valid && (op == OP_RD);
  assign wr_issue  = cmd_valid && (op == OP_WR);
  assign col_issue = rd_issue || wr_issue;

  // per-bank trackers
  logic [NBANK-1:0] row_open;
  logic [NBANK-1:0] e_act_open, e_col_closed, e_rd_early, e_wr_early, e_pre_rd, e_pre_wr;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic bank_hit;
    assign bank_hit = cmd_valid && (cmd_bank == BW'(b));
    rtm_bank_tracker #(
      .CNTW(CNTW), .RD_ACT_MIN(RD_ACT_MIN), .WR_ACT_MIN(WR_ACT_MIN),
      .RD_PRE_MIN(RD_PRE_MIN), .WR_PRE_MIN(WR_PRE_MIN)
    ) u_trk (
      .clk(clk), .rst_n(rst_n), .hit(bank_hit), .op(op),
      .row_open(row_open[b]),
      .e_act_open(e_act_open[b]), .e_col_closed(e_col_closed[b]),
      .e_rd_early(e_rd_early[b]), .e_wr_early(e_wr_early[b]),
      .e_pre_rd(e_pre_rd[b]), .e_pre_wr(e_pre_wr[b])
    );
  end

  // spacing between column commands on any bank
  logic [CNTW-1:0] col_age;
  always_ff @(posedge clk) begin
    if (!rst_n)              col_age <= '1;
    else if (col_issue)      col_age <= CNTW'(1);
    else if (col_age != '1)  col_age <= col_age + CNTW'(1);
  end

  logic e_col_gap;
  assign e_col_gap = col_issue && gap_short(16'(col_age), 16'(COL_GAP_MIN));

  // data arrival window
  logic          exp_now, e_miss, e_extra;
  logic [BW-1:0] exp_bank;

  rtm_data_window #(.RD_LAT(RD_LAT), .WR_LAT(WR_LAT), .BW(BW)) u_win (
    .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue), .wr_issue(wr_issue),
    .bank(cmd_bank), .data_valid(data_valid),
    .exp_now(exp_now), .exp_bank(exp_bank), .e_miss(e_miss), .e_extra(e_extra)
  );

  // violation vector, bit i = code i+1
  logic [NCODE-1:0] hits;
  assign hits = {e_extra, e_miss, |e_pre_wr, |e_pre_rd, e_col_gap,
                 |e_wr_early, |e_rd_early, |e_col_closed, |e_act_open};

  function automatic logic [BW-1:0] bank_of(input logic [CODEW-1:0] c,
                                            input logic [BW-1:0] cb,
                                            input logic [BW-1:0] db);
    if (c == C_DATA_MISS)       return db;
    else if (c == C_DATA_EXTRA) return '0;
    else                        return cb;
  endfunction

  logic [CODEW-1:0] new_code;
  logic [BW-1:0]    new_bank;
  assign new_code = first_code(hits);
  assign new_bank = bank_of(new_code, cmd_bank, exp_bank);

  rtm_err_log #(.BW(BW)) u_log (
    .clk(clk), .rst_n(rst_n), .err_clear(err_clear), .hits(hits),
    .new_code(new_code), .new_bank(new_bank),
    .flags(err_flags), .code(err_code), .bank(err_bank)
  );

endmodule

// File: rtl/rtm_monitor_chk.sv
module rtm_monitor_chk
  import rtm_pkg::*;
#(
  parameter int NBANK = 8,
  parameter int BW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic [BW-1:0]    cmd_bank,
  input logic             data_valid,
  input logic             err_clear,
  input logic [NBANK-1:0] row_open,
  input logic             exp_now,
  input logic [NCODE-1:0] err_flags,
  input logic [CODEW-1:0] err_code,
  input logic [BW-1:0]    err_bank
);

  logic col_to_closed;
  assign col_to_closed = cmd_valid && (cmd_op == 2'd1 || cmd_op == 2'd2) && !row_open[cmd_bank];

  AST_COL_CLOSED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    col_to_closed |=> err_flags[1]); // R1

  AST_MISSING_DATA_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_now && !data_valid) |=> err_flags[7]); // R6

  AST_EXTRA_DATA_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && !exp_now) |=> err_flags[8]); // R7

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clear |=> ((err_flags & $past(err_flags)) == $past(err_flags))); // R8

  AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_clear && err_flags != '0) |=> ($stable(err_code) && $stable(err_bank))); // R9

  AST_CODE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags != '0) |-> (((err_flags >> (err_code - 4'd1)) & NCODE'(1)) != '0)); // R9

  AST_EMPTY_LOG: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags == '0) |-> (err_code == '0 && err_bank == '0)); // R11

endmodule

bind rtm_monitor rtm_monitor_chk #(.NBANK(NBANK), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_bank(cmd_bank), .data_valid(data_valid), .err_clear(err_clear),
  .row_open(row_open), .exp_now(exp_now), .err_flags(err_flags),
  .err_code(err_code), .err_bank(err_bank)
);

// File: tb/tb_rtm_monitor.sv
module tb_rtm_monitor;

  localparam int OP_ACT = 0, OP_RD = 1, OP_WR = 2, OP_PRE = 3;
  localparam int NEVER = -1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [2:0] cmd_bank = 3'd0;
  logic       data_valid = 1'b0;
  logic       err_clear = 1'b0;
  logic [8:0] err_flags;
  logic [3:0] err_code;
  logic [2:0] err_bank;

  rtm_monitor dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .data_valid(data_valid), .err_clear(err_clear),
    .err_flags(err_flags), .err_code(err_code), .err_bank(err_bank)
  );

  always #2 clk = ~clk; // 250 MHz

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;
  int dv_mode = 0; // 0 follow model, 1 force low, 2 force high

  // reference model, absolute cycle stamps
  int cyc;
  int last_act [8];
  int last_rd  [8];
  int last_wr  [8];
  bit open_row [8];
  int last_col;
  bit exp_tbl [64];
  int exp_bk  [64];
  int m_flags, m_code, m_bank;

  function automatic void model_reset();
    cyc = 0; last_col = NEVER;
    for (int b = 0; b < 8; b++) begin
      last_act[b] = NEVER; last_rd[b] = NEVER; last_wr[b] = NEVER; open_row[b] = 0;
    end
    for (int i = 0; i < 64; i++) begin exp_tbl[i] = 0; exp_bk[i] = 0; end
    m_flags = 0; m_code = 0; m_bank = 0;
  endfunction

  function automatic bit model_expects();
    return exp_tbl[cyc % 64];
  endfunction

  function automatic void model_step(bit v, int op, int bk, bit dv, bit clr);
    int hits = 0;
    int miss_bank = 0;
    int code = 0, bank = 0;
    bit ex = exp_tbl[cyc % 64];
    if (ex && !dv) begin hits |= 1 << 7; miss_bank = exp_bk[cyc % 64]; end
    if (dv && !ex) hits |= 1 << 8;
    exp_tbl[cyc % 64] = 0;
    if (v) begin
      case (op)
        OP_ACT: begin
          if (open_row[bk]) hits |= 1 << 0;
          open_row[bk] = 1; last_act[bk] = cyc;
        end
        OP_RD, OP_WR: begin
          if (!open_row[bk]) hits |= 1 << 1;
          if (op == OP_RD && cyc - last_act[bk] < 5) hits |= 1 << 2;
          if (op == OP_WR && cyc - last_act[bk] < 1) hits |= 1 << 3;
          if (cyc - last_col < 2) hits |= 1 << 4;
          last_col = cyc;
          if (op == OP_RD) begin
            last_rd[bk] = cyc; exp_tbl[(cyc + 6) % 64] = 1; exp_bk[(cyc + 6) % 64] = bk;
          end else begin
            last_wr[bk] = cyc; exp_tbl[(cyc + 3) % 64] = 1; exp_bk[(cyc + 3) % 64] = bk;
          end
        end
        default: begin
          if (cyc - last_rd[bk] < 3)  hits |= 1 << 5;
          if (cyc - last_wr[bk] < 10) hits |= 1 << 6;
          open_row[bk] = 0;
        end
      endcase
    end
    for (int i = 8; i >= 0; i--) if (hits[i]) code = i + 1;
    if (code == 8) bank = miss_bank;
    else if (code == 9) bank = 0;
    else bank = bk;
    if (hits != 0 && (clr || m_flags == 0)) begin m_code = code; m_bank = bank; end
    else if (clr) begin m_code = 0; m_bank = 0; end
    m_flags = clr ? hits : (m_flags | hits);
    cyc++;
  endfunction

  task automatic check3(string req, int ef, int ec, int eb);
    n_checks++;
    if (err_flags !== 9'(ef) || err_code !== 4'(ec) || err_bank !== 3'(eb)) begin
      n_errors++;
      $display("FAIL %s: flags=%h code=%0d bank=%0d expected flags=%h code=%0d bank=%0d",
               req, err_flags, err_code, err_bank, ef, ec, eb);
    end
  endtask

  // one cycle: settle data valid, clock, compare against model (R8 R9)
  task automatic tick();
    case (dv_mode)
      1: data_valid = 1'b0;
      2: data_valid = 1'b1;
      default: data_valid = model_expects();
    endcase
    @(posedge clk);
    @(negedge clk);
    model_step(cmd_valid, int'(cmd_op), int'(cmd_bank), data_valid, err_clear);
    check3("R8 R9 model", m_flags, m_code, m_bank);
  endtask

  task automatic issue(int op, int bk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_bank = 3'(bk);
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic clear_log();
    err_clear = 1'b1; tick(); err_clear = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cmd_valid = 1'b0; err_clear = 1'b0; data_valid = 1'b0;
    repeat (3) @(negedge clk);
    model_reset();
    check3("R11 reset", 0, 0, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R1 activate to an open row
    issue(OP_ACT, 3); idle(5); issue(OP_ACT, 3);
    check3("R1 act open", 9'h001, 1, 3);
    // R1 column to a closed row
    clear_log(); issue(OP_RD, 5);
    check3("R1 col closed", 9'h002, 2, 5);
    idle(8);
    // R2 read too early
    clear_log(); issue(OP_ACT, 1); idle(3); issue(OP_RD, 1);
    check3("R2 rd early", 9'h004, 3, 1);
    idle(8);
    // R2 boundaries: read at +5, write at +1
    clear_log(); issue(OP_ACT, 4); idle(4); issue(OP_RD, 4); idle(2);
    issue(OP_ACT, 6); issue(OP_WR, 6); idle(8);
    check3("R2 boundary", 0, 0, 0);
    // R3 column spacing across banks
    clear_log(); issue(OP_RD, 4); issue(OP_WR, 6);
    check3("R3 col gap", 9'h010, 5, 6);
    idle(10);
    // R4 precharge too soon after read
    clear_log(); issue(OP_RD, 4); idle(1); issue(OP_PRE, 4);
    check3("R4 pre after rd", 9'h020, 6, 4);
    idle(8);
    // R4 boundary at +3
    clear_log(); issue(OP_ACT, 4); idle(4); issue(OP_RD, 4); idle(2); issue(OP_PRE, 4); idle(8);
    check3("R4 boundary", 0, 0, 0);
    // R5 precharge too soon after write
    clear_log(); issue(OP_WR, 6); idle(8); issue(OP_PRE, 6);
    check3("R5 pre after wr", 9'h040, 7, 6);
    idle(4);
    // R5 boundary at +10
    clear_log(); issue(OP_ACT, 6); issue(OP_WR, 6); idle(9); issue(OP_PRE, 6); idle(2);
    check3("R5 boundary", 0, 0, 0);
    // R6 read data missing
    clear_log(); issue(OP_ACT, 2); idle(4); issue(OP_RD, 2);
    dv_mode = 1; idle(6); dv_mode = 0;
    check3("R6 missing data", 9'h080, 8, 2);
    // R7 unexpected data
    clear_log(); dv_mode = 2; idle(1); dv_mode = 0;
    check3("R7 extra data", 9'h100, 9, 0);
    // R9 simultaneous gap violation and extra data
    clear_log(); idle(2); issue(OP_RD, 2);
    dv_mode = 2; issue(OP_RD, 2); dv_mode = 0;
    check3("R9 same cycle", 9'h110, 5, 2);
    idle(8);
    // R8 violation in the clear cycle is kept, then held
    err_clear = 1'b1; dv_mode = 2; tick(); err_clear = 1'b0; dv_mode = 0;
    check3("R8 clear with error", 9'h100, 9, 0);
    idle(3);
    check3("R8 hold", 9'h100, 9, 0);
    clear_log();
    check3("R8 cleared", 0, 0, 0);
    // R10 precharge to closed bank, independent banks
    issue(OP_PRE, 7);
    check3("R10 pre closed", 0, 0, 0);
    issue(OP_ACT, 5); idle(1); issue(OP_RD, 1); idle(8);
    check3("R10 independent banks", 0, 0, 0);

    // constrained random traffic against the model
    do_reset();
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < 3000; n++) begin
      cmd_valid = ($urandom_range(0, 9) < 4);
      cmd_op    = 2'($urandom_range(0, 3));
      cmd_bank  = 3'($urandom_range(0, 7));
      err_clear = ($urandom_range(0, 31) == 0);
      dv_mode   = ($urandom_range(0, 24) == 0) ? (model_expects() ? 1 : 2) : 0;
      tick();
    end
    cmd_valid = 1'b0; err_clear = 1'b0; dv_mode = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule